// File: doc/BRIEF.md
# Voltage-Code Register Slave on a Two-Wire Bus

This block lets a host processor program the output level of a step-down regulator over a two-wire serial bus. It acts as a target only. It accepts a single-byte write, which is a target address, a register index and one data byte. It also accepts a single-byte read, which is a target address, a register index, a repeated START, the target address with the read bit, and one byte returned by the block. The block never stretches the clock and supports no other transfer form.

The SCL and SDA inputs arrive already synchronised and de-glitched in the system clock domain. The block drives only a pull-down enable for the open-drain SDA line. The host can reach two registers. The first holds the 7-bit voltage code together with a check bit. The second reports the regulator's power-good input. When a voltage code is accepted, it appears on a dedicated output, a one-cycle strobe marks the update, and a sticky flag records that the regulator is now under bus control.

Top module: `vid_i2c_slave`

## Requirements
- R1: After reset the voltage code output is 0x32, the bus-control flag is 0, the update strobe is 0 and the SDA pull-down enable is 0.
- R2: The block ignores all bus traffic (it never acknowledges and never updates) until a clock cycle occurs in which SCL, SDA and the regulation-reached input are all high. From then on the bus stays live until reset.
- R3: The 7-bit target address is 0x31, so address bytes are 0x62 for a write and 0x63 for a read. A matching address byte is acknowledged by pulling SDA low in the ninth clock. Any other address is not acknowledged, and every later byte is ignored until the next START.
- R4: In a write transfer, the address byte, a valid register index and the data byte are each acknowledged.
- R5: Register index 0x00 is the voltage register and index 0x18 is the status register. Any other index is not acknowledged, and the rest of that transfer is ignored. Writes to 0x18 are acknowledged but change nothing.
- R6: A data byte written to index 0x00 is accepted only if bit 7 equals the XOR of bits 6:0. A rejected byte is still acknowledged, but it leaves the code, the flag and the strobe unchanged.
- R7: An accepted byte's bits 6:0 appear on the code output in the clock cycle after the cycle in which its last bit is sampled. In that same cycle the strobe is high for exactly one cycle, and the bus-control flag is set and stays set.
- R8: In a read transfer the block returns the selected register most significant bit first and then releases SDA. Index 0x00 reads as {XOR of the code, code}, which is 0xB2 after reset. Index 0x18 reads as seven zero bits above the power-good input in bit 0.
- R9: A START, whether it is a repeated START or one that arrives in the middle of a byte, restarts reception at the address byte. A STOP returns the block to idle with SDA released.
- R10: Input bits are sampled on the rising edge of SCL. The SDA pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (wired bus value) |
| sda_oe_o | output | 1 | SDA pull-down enable (1 = drive low) |
| reg_ok_i | input | 1 | Regulator has reached regulation |
| pgood_i | input | 1 | Power-good level reported in the status register |
| vid_code_o | output | 7 | Accepted voltage code |
| vid_mode_o | output | 1 | Sticky flag: a code has been accepted over the bus |
| code_load_o | output | 1 | One-cycle strobe on each accepted code |

## Verification
The parity decision, the register update with its strobe, and the acknowledge decision for the data byte all fall on the same SCL rising edge, the one that samples the eighth data bit. The bench provokes this edge with valid codes, with a corrupted check bit and with writes to the read-only index. Its model predicts that code and strobe change in the very next clock while the acknowledge appears only after the following SCL fall. It compares code, flag and strobe on every clock and SDA at the middle of each high phase. A START that cuts a byte short is also provoked, to show that it pre-empts any sampling edge.

// File: rtl/vid_pkg.sv
package vid_pkg;
    localparam int DATA_W = 8;
    localparam int CODE_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        PS_IDLE, PS_RECV, PS_ACKW, PS_ACK, PS_SEND, PS_SKIP
    } pstate_t;

    typedef enum logic [1:0] {
        BY_ADDR, BY_REG, BY_DATA
    } byte_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic armed;
    } cond_s;

    typedef struct packed {
        pstate_t           st;
        byte_t             byt;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shft;
        logic [DATA_W-1:0] ptr;
        logic              rd;
        logic              oe;
    } proto_s;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              mode;
        logic              load;
    } vreg_s;
endpackage

// File: rtl/vid_bus_cond.sv
module vid_bus_cond
    import vid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic reg_ok_i,
    output logic armed_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    cond_s cond_d, cond_q;

    always_comb begin
        cond_d       = cond_q;
        cond_d.scl   = scl_i;
        cond_d.sda   = sda_i;
        cond_d.armed = cond_q.armed | (scl_i & sda_i & reg_ok_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= '{scl: 1'b1, sda: 1'b1, armed: 1'b0};
        else        cond_q <= cond_d;
    end

    assign armed_o    = cond_q.armed;
    assign scl_rise_o = cond_q.armed &  scl_i & ~cond_q.scl;
    assign scl_fall_o = cond_q.armed & ~scl_i &  cond_q.scl;
    assign start_o    = cond_q.armed & scl_i & cond_q.scl &  cond_q.sda & ~sda_i;
    assign stop_o     = cond_q.armed & scl_i & cond_q.scl & ~cond_q.sda &  sda_i;

    // R2
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_q.armed |=> cond_q.armed);
    // R2
    armed_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cond_q.armed) |-> $past(scl_i && sda_i && reg_ok_i));
endmodule

// File: rtl/vid_regs.sv
module vid_regs
    import vid_pkg::*;
#(
    parameter logic [DATA_W-1:0] REG_VID   = 8'h00,
    parameter logic [DATA_W-1:0] REG_PG    = 8'h18,
    parameter logic [CODE_W-1:0] VID_RESET = 7'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] ptr_i,
    input  logic              pgood_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CODE_W-1:0] code_o,
    output logic              mode_o,
    output logic              load_o
);
    vreg_s vr_d, vr_q;
    logic  check_ok;

    assign check_ok = (wr_data_i[DATA_W-1] == ^wr_data_i[CODE_W-1:0]);

    always_comb begin
        vr_d      = vr_q;
        vr_d.load = 1'b0;
        if (wr_en_i && ptr_i == REG_VID && check_ok) begin
            vr_d.code = wr_data_i[CODE_W-1:0];
            vr_d.mode = 1'b1;
            vr_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vr_q <= '{code: VID_RESET, mode: 1'b0, load: 1'b0};
        else        vr_q <= vr_d;
    end

    always_comb begin
        if (ptr_i == REG_VID)     rdata_o = {^vr_q.code, vr_q.code};
        else if (ptr_i == REG_PG) rdata_o = {{CODE_W{1'b0}}, pgood_i};
        else                      rdata_o = '0;
    end

    assign code_o = vr_q.code;
    assign mode_o = vr_q.mode;
    assign load_o = vr_q.load;

    // R7
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vr_q.load |=> !vr_q.load);
    // R7
    code_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vr_q.code) |-> vr_q.load);
    // R7
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vr_q.mode |=> vr_q.mode);
    // R6
    bad_check_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_data_i[DATA_W-1] != ^wr_data_i[CODE_W-1:0])) |=> ($stable(vr_q.code) && !vr_q.load));
endmodule

// File: rtl/vid_proto.sv
module vid_proto
    import vid_pkg::*;
#(
    parameter logic [CODE_W-1:0] SLAVE_ADDR = 7'h31,
    parameter logic [DATA_W-1:0] REG_VID    = 8'h00,
    parameter logic [DATA_W-1:0] REG_PG     = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              armed_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] ptr_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    proto_s pr_d, pr_q;
    logic [DATA_W-1:0] full_byte;

    assign full_byte = {pr_q.shft[DATA_W-2:0], sda_i};

    always_comb begin
        pr_d    = pr_q;
        wr_en_o = 1'b0;
        if (start_i) begin
            pr_d.st  = PS_RECV;
            pr_d.byt = BY_ADDR;
            pr_d.cnt = '0;
            pr_d.rd  = 1'b0;
            pr_d.oe  = 1'b0;
        end else if (stop_i) begin
            pr_d.st = PS_IDLE;
            pr_d.oe = 1'b0;
        end else begin
            unique case (pr_q.st)
                PS_RECV: if (scl_rise_i) begin
                    pr_d.shft = full_byte;
                    pr_d.cnt  = pr_q.cnt + 1'b1;
                    if (pr_q.cnt == LAST_BIT) begin
                        pr_d.st = PS_SKIP;
                        unique case (pr_q.byt)
                            BY_ADDR: if (full_byte[DATA_W-1:1] == SLAVE_ADDR) begin
                                pr_d.st = PS_ACKW;
                                pr_d.rd = full_byte[0];
                            end
                            BY_REG: if (full_byte == REG_VID || full_byte == REG_PG) begin
                                pr_d.st  = PS_ACKW;
                                pr_d.ptr = full_byte;
                            end
                            default: begin
                                pr_d.st = PS_ACKW;
                                wr_en_o = 1'b1;
                            end
                        endcase
                    end
                end
                PS_ACKW: if (scl_fall_i) begin
                    pr_d.oe = 1'b1;
                    pr_d.st = PS_ACK;
                end
                PS_ACK: if (scl_fall_i) begin
                    pr_d.oe  = 1'b0;
                    pr_d.cnt = '0;
                    unique case (pr_q.byt)
                        BY_ADDR: if (pr_q.rd) begin
                            pr_d.st   = PS_SEND;
                            pr_d.shft = {rdata_i[DATA_W-2:0], 1'b0};
                            pr_d.oe   = ~rdata_i[DATA_W-1];
                        end else begin
                            pr_d.st  = PS_RECV;
                            pr_d.byt = BY_REG;
                        end
                        BY_REG: begin
                            pr_d.st  = PS_RECV;
                            pr_d.byt = BY_DATA;
                        end
                        default: pr_d.st = PS_SKIP;
                    endcase
                end
                PS_SEND: if (scl_fall_i) begin
                    if (pr_q.cnt == LAST_BIT) begin
                        pr_d.oe = 1'b0;
                        pr_d.st = PS_SKIP;
                    end else begin
                        pr_d.oe   = ~pr_q.shft[DATA_W-1];
                        pr_d.shft = {pr_q.shft[DATA_W-2:0], 1'b0};
                        pr_d.cnt  = pr_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '{st: PS_IDLE, byt: BY_ADDR, cnt: '0, shft: '0,
                              ptr: REG_VID, rd: 1'b0, oe: 1'b0};
        else        pr_q <= pr_d;
    end

    assign sda_oe_o  = pr_q.oe;
    assign wr_data_o = full_byte;
    assign ptr_o     = pr_q.ptr;

    // R10
    oe_scl_high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(pr_q.oe));
    // R2
    oe_dead_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |-> !pr_q.oe);
    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!pr_q.oe && pr_q.st == PS_IDLE));
    // R5
    ptr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_q.ptr == REG_VID || pr_q.ptr == REG_PG));
endmodule

// File: rtl/vid_i2c_slave.sv
module vid_i2c_slave
    import vid_pkg::*;
#(
    parameter logic [CODE_W-1:0] SLAVE_ADDR = 7'h31,
    parameter logic [DATA_W-1:0] REG_VID    = 8'h00,
    parameter logic [DATA_W-1:0] REG_PG     = 8'h18,
    parameter logic [CODE_W-1:0] VID_RESET  = 7'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              reg_ok_i,
    input  logic              pgood_i,
    output logic [CODE_W-1:0] vid_code_o,
    output logic              vid_mode_o,
    output logic              code_load_o
);
    logic armed, scl_rise, scl_fall, start_c, stop_c, wr_en;
    logic [DATA_W-1:0] wr_data, ptr, rdata;

    vid_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .reg_ok_i(reg_ok_i),
        .armed_o(armed), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_c), .stop_o(stop_c)
    );

    vid_proto #(.SLAVE_ADDR(SLAVE_ADDR), .REG_VID(REG_VID), .REG_PG(REG_PG)) u_proto (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .armed_i(armed),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_c), .stop_i(stop_c),
        .rdata_i(rdata), .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .wr_data_o(wr_data),
        .ptr_o(ptr)
    );

    vid_regs #(.REG_VID(REG_VID), .REG_PG(REG_PG), .VID_RESET(VID_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .ptr_i(ptr),
        .pgood_i(pgood_i), .rdata_o(rdata), .code_o(vid_code_o), .mode_o(vid_mode_o),
        .load_o(code_load_o)
    );
endmodule

// File: tb/sim_vid_i2c_slave.sv
module sim_vid_i2c_slave;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, scl, m_sda, reg_ok, pgood;
    logic sda_oe, mode, load;
    logic [6:0] code;
    wire  sda_bus = m_sda & ~sda_oe;

    int vectors = 0, miscompares = 0;
    logic [6:0] exp_code = 7'h32;
    logic exp_mode = 1'b0, exp_load = 1'b0, pend = 1'b0;
    logic [6:0] pend_code = '0;

    vid_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .reg_ok_i(reg_ok), .pgood_i(pgood), .vid_code_o(code), .vid_mode_o(mode),
        .code_load_o(load)
    );

    // Reference model: every clock, code/flag/strobe against the behavioural expectation (R7)
    task automatic tick();
        @(negedge clk);
        exp_load = pend;
        if (pend) begin
            exp_code = pend_code;
            exp_mode = 1'b1;
            pend     = 1'b0;
        end
        vectors++;
        if (code !== exp_code || mode !== exp_mode || load !== exp_load) begin
            miscompares++;
            $display("FAIL R7 per-clock: code=%h mode=%b load=%b expected code=%h mode=%b load=%b",
                     code, mode, load, exp_code, exp_mode, exp_load);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check_oe(input logic exp, input string tag);
        vectors++;
        if (sda_oe !== exp) begin
            miscompares++;
            $display("FAIL %s: sda_oe=%b expected %b", tag, sda_oe, exp);
        end
    endtask

    task automatic start_c();
        scl = 1'b0; wait_n(2); m_sda = 1'b1; wait_n(2);
        scl = 1'b1; wait_n(2); m_sda = 1'b0; wait_n(2);
    endtask

    task automatic stop_c();
        scl = 1'b0; wait_n(2); m_sda = 1'b0; wait_n(2);
        scl = 1'b1; wait_n(2); m_sda = 1'b1; wait_n(2);
    endtask

    task automatic put_bit(input logic b, input logic commit, input logic [6:0] c);
        scl = 1'b0; wait_n(2); m_sda = b; wait_n(2);
        scl = 1'b1;
        if (commit) begin pend = 1'b1; pend_code = c; end
        wait_n(4);
    endtask

    task automatic wr_byte(input logic [7:0] d, input logic commit, input logic ack, input string tag);
        for (int i = 7; i >= 0; i--) put_bit(d[i], commit && (i == 0), d[6:0]);
        scl = 1'b0; wait_n(2); m_sda = 1'b1; wait_n(2);
        scl = 1'b1; wait_n(1); check_oe(ack, tag); wait_n(3);
    endtask

    task automatic rd_byte(input logic [7:0] d, input string tag);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; wait_n(2); m_sda = 1'b1; wait_n(2);
            scl = 1'b1; wait_n(1); check_oe(~d[i], tag);
            wait_n(2); check_oe(~d[i], "R10 held while SCL high"); wait_n(1);
        end
        scl = 1'b0; wait_n(2); m_sda = 1'b1; wait_n(2);
        scl = 1'b1; wait_n(1); check_oe(1'b0, "R8 released after byte"); wait_n(3);
    endtask

    task automatic write_txn(input logic [7:0] ra, input logic [7:0] d, input logic commit, input string tag);
        start_c();
        wr_byte(8'h62, 1'b0, 1'b1, "R4 address ack");
        wr_byte(ra, 1'b0, 1'b1, "R4 register ack");
        wr_byte(d, commit, 1'b1, tag);
        stop_c();
    endtask

    task automatic read_txn(input logic [7:0] ra, input logic [7:0] d, input string tag);
        start_c();
        wr_byte(8'h62, 1'b0, 1'b1, "R3 address ack");
        wr_byte(ra, 1'b0, 1'b1, "R5 register ack");
        start_c();
        wr_byte(8'h63, 1'b0, 1'b1, "R9 repeated START read address ack");
        rd_byte(d, tag);
        stop_c();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; reg_ok = 1'b0; pgood = 1'b1;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        vectors++;
        if (code !== 7'h32 || mode !== 1'b0 || load !== 1'b0 || sda_oe !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: code=%h mode=%b load=%b oe=%b expected 32 0 0 0", code, mode, load, sda_oe);
        end

        // R2 bus dead before regulation reached
        start_c();
        wr_byte(8'h62, 1'b0, 1'b0, "R2 no ack while unarmed");
        wr_byte(8'h00, 1'b0, 1'b0, "R2 no ack while unarmed");
        wr_byte(8'hC5, 1'b0, 1'b0, "R2 no update while unarmed");
        stop_c();
        reg_ok = 1'b1;
        wait_n(4);

        // R8 reset readback
        read_txn(8'h00, 8'hB2, "R8 reset readback");
        // R4/R7 valid write
        write_txn(8'h00, 8'hC5, 1'b1, "R4 data ack");
        read_txn(8'h00, 8'hC5, "R8 readback after write");
        // R6 bad check bit
        write_txn(8'h00, 8'h45, 1'b0, "R6 bad check still acked");
        write_txn(8'h00, 8'h80, 1'b0, "R6 bad check still acked");
        read_txn(8'h00, 8'hC5, "R6 register unchanged");
        // R3 wrong address then ignore
        start_c();
        wr_byte(8'h64, 1'b0, 1'b0, "R3 wrong address nack");
        wr_byte(8'h00, 1'b0, 1'b0, "R3 ignored after mismatch");
        wr_byte(8'h80, 1'b0, 1'b0, "R3 ignored after mismatch");
        stop_c();
        // R5 unknown register
        start_c();
        wr_byte(8'h62, 1'b0, 1'b1, "R5 address ack");
        wr_byte(8'h05, 1'b0, 1'b0, "R5 unknown register nack");
        wr_byte(8'h00, 1'b0, 1'b0, "R5 transfer abandoned");
        stop_c();
        // R5 read-only status register
        write_txn(8'h18, 8'hFF, 1'b0, "R5 status write acked");
        read_txn(8'h18, 8'h01, "R8 status pgood=1");
        pgood = 1'b0;
        read_txn(8'h18, 8'h00, "R8 status pgood=0");
        // boundary codes
        write_txn(8'h00, 8'h00, 1'b1, "R7 code zero accepted");
        read_txn(8'h00, 8'h00, "R8 readback zero");
        // R9 START in the middle of a byte
        start_c();
        put_bit(1'b1, 1'b0, 7'h0); put_bit(1'b0, 1'b0, 7'h0); put_bit(1'b1, 1'b0, 7'h0);
        start_c();
        wr_byte(8'h62, 1'b0, 1'b1, "R9 restart after mid-byte START");
        wr_byte(8'h00, 1'b0, 1'b1, "R9 register ack");
        wr_byte(8'hFF, 1'b1, 1'b1, "R9 data ack, code 7F");
        stop_c();
        vectors++;
        if (sda_oe !== 1'b0) begin
            miscompares++;
            $display("FAIL R9: oe=%b after STOP expected 0", sda_oe);
        end
        read_txn(8'h00, 8'hFF, "R8 readback 7F");
        wait_n(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule